// File: doc/BRIEF.md
# Security State Transition Controller

This block holds the processor's current security state (Secure or Non-secure) and decides, one event per clock, whether a decoded branch event may change it. The decode stage presents a branch event code, the branch target, the true return address, the current link value, the security attribute of the fetched address and the value at the top of the Secure stack. The block answers with the new state, a link-value write, a push or pop request for the Secure stack, a redirect address and a one-cycle fault flag.

Leaving Secure state is controlled by the least significant bit of the target address. Entering Secure state is possible only through a gateway executed at a Non-secure Callable address, or through a branch to the reserved return token (0xFEFFFFFF). The token pops the Secure stack and continues at the popped address. The block counts the Secure stack's occupancy itself. The stack storage lives outside the block.

Top module: `sec_state_ctrl`

## Requirements
- R1: While and after reset (rst_n low), sec_state_o is 1 (Secure) and link_wr_o, push_req_o, pop_req_o, redirect_vld_o and fault_o are 0. The Secure stack count is zero.
- R2: In Secure state, event code 1 (non-secure branch) or code 2 (non-secure branch-with-link) with target_i[0] = 0 makes sec_state_o 0 on the cycle after the event. For either code, redirect_vld_o pulses with redirect_addr_o equal to target_i with bit 0 cleared.
- R3: In Secure state, event code 2 with target_i[0] = 0 and the stack not full writes 0xFEFFFFFF on link_o with link_wr_o = 1. It also raises push_req_o with push_data_o equal to ret_addr_i, and adds one to the stack count.
- R4: In Non-secure state, event code 3 (gateway) with fetch_attr_i = 1 (Non-secure Callable) makes sec_state_o 1. It writes link_in_i with bit 0 cleared on link_o, with link_wr_o = 1.
- R5: Event code 3 in any other situation leaves sec_state_o unchanged and keeps link_wr_o at 0. The other situations are Secure state, or fetch_attr_i of 0 (Non-secure).
- R6: In Non-secure state, event code 4 (branch to return token) with a non-empty stack makes sec_state_o 1. It raises pop_req_o, redirects to stack_top_i and takes one from the stack count.
- R7: Event code 4 in Non-secure state with an empty stack raises fault_o for one cycle. The state stays Non-secure and no pop is requested.
- R8: In Non-secure state, fetch_vld_i = 1 with fetch_attr_i of 2 or 3 (Secure) raises fault_o for one cycle. The event of that cycle is discarded: no state change, no link write, no push or pop.
- R9: Event code 2 that would leave Secure state while the stack holds STACK_DEPTH entries raises fault_o. The state stays Secure and nothing is pushed.
- R10: Event code 1 in Non-secure state and event code 4 in Secure state have no effect: the state is unchanged and no fault, pop or link write occurs.
- R11: All outputs are registered. Results appear on the cycle after the event, and link_wr_o, push_req_o, pop_req_o, redirect_vld_o and fault_o are single-cycle pulses per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 3 | Event code: 0 none, 1 ns branch, 2 ns branch-with-link, 3 gateway, 4 return-token branch |
| target_i | input | 32 | Branch target address |
| ret_addr_i | input | 32 | True return address of a branch-with-link |
| link_in_i | input | 32 | Current link value seen by a gateway |
| fetch_vld_i | input | 1 | Fetch attribute is valid this cycle |
| fetch_attr_i | input | 2 | Attribute of fetched address: 0 NS, 1 NSC, 2/3 Secure |
| stack_top_i | input | 32 | Value at the top of the Secure stack |
| sec_state_o | output | 1 | 1 = Secure, 0 = Non-secure |
| link_wr_o | output | 1 | Link write strobe |
| link_o | output | 32 | New link value |
| push_req_o | output | 1 | Secure-stack push request |
| push_data_o | output | 32 | Value to push |
| pop_req_o | output | 1 | Secure-stack pop request |
| redirect_vld_o | output | 1 | Fetch redirect strobe |
| redirect_addr_o | output | 32 | Redirect target |
| fault_o | output | 1 | One-cycle security fault |

## Verification
The properties assume that the decode stage presents at most one event code per clock. They also assume that a gateway event arrives with fetch_vld_i high and the attribute of its own address, and that stack_top_i holds the pushed value whenever the count is non-zero. The directed stimulus drives only codes 0 to 4. It returns each pushed return address on stack_top_i before issuing a token branch. It applies a gateway only together with a valid attribute, and it changes inputs only midway between rising edges.

// File: rtl/sstc_pkg.sv
// Package: shared widths, event and attribute codes, and the per-cycle
// decision record passed from rule evaluation to the output registers.
package sstc_pkg;

    localparam int ADDR_W = 32;
    localparam logic [ADDR_W-1:0] RET_TOKEN = 32'hFEFF_FFFF;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_NS_BR  = 3'd1,
        EV_NS_BRL = 3'd2,
        EV_GATE   = 3'd3,
        EV_TOKEN  = 3'd4
    } ev_e;

    typedef enum logic [1:0] {
        AT_NS  = 2'd0,
        AT_NSC = 2'd1,
        AT_S   = 2'd2,
        AT_S2  = 2'd3
    } attr_e;

    typedef struct packed {
        logic              next_sec;
        logic              link_wr;
        logic [ADDR_W-1:0] link_val;
        logic              push;
        logic [ADDR_W-1:0] push_val;
        logic              pop;
        logic              redir;
        logic [ADDR_W-1:0] redir_val;
        logic              fault;
    } decision_t;

endpackage

// File: rtl/sstc_rule_eval.sv
// Module: sstc_rule_eval
// Combinational transition rules. Given the current security state, the
// event of this cycle and the stack occupancy flags, it produces the full
// decision for the next cycle.
// Assumes at most one event per cycle; codes above 4 are treated as no event.
module sstc_rule_eval
    import sstc_pkg::*;
(
    input  logic              cur_sec,
    input  logic [2:0]        ev,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] link_in,
    input  logic              fetch_vld,
    input  logic [1:0]        fetch_attr,
    input  logic [ADDR_W-1:0] stack_top,
    input  logic              stk_empty,
    input  logic              stk_full,
    output decision_t         dec
);

    logic fetch_fault;
    logic attr_secure;
    logic leave_ok;

    // Classify the fetched attribute and detect an illegal Non-secure fetch.
    always_comb begin
        attr_secure = (fetch_attr == AT_S) || (fetch_attr == AT_S2);
        fetch_fault = !cur_sec && fetch_vld && attr_secure;
        leave_ok    = cur_sec && !target[0];
    end

    // Apply the transition rules for the current event.
    always_comb begin
        dec           = '0;
        dec.next_sec  = cur_sec;
        if (fetch_fault) begin
            dec.fault = 1'b1;
        end else begin
            case (ev)
                EV_NS_BR: begin
                    if (cur_sec) begin
                        dec.redir     = 1'b1;
                        dec.redir_val = {target[ADDR_W-1:1], 1'b0};
                        if (leave_ok) dec.next_sec = 1'b0;
                    end
                end
                EV_NS_BRL: begin
                    if (cur_sec) begin
                        if (leave_ok && stk_full) begin
                            dec.fault = 1'b1;
                        end else begin
                            dec.redir     = 1'b1;
                            dec.redir_val = {target[ADDR_W-1:1], 1'b0};
                            if (leave_ok) begin
                                dec.next_sec = 1'b0;
                                dec.link_wr  = 1'b1;
                                dec.link_val = RET_TOKEN;
                                dec.push     = 1'b1;
                                dec.push_val = ret_addr;
                            end
                        end
                    end
                end
                EV_GATE: begin
                    if (!cur_sec && fetch_vld && (fetch_attr == AT_NSC)) begin
                        dec.next_sec = 1'b1;
                        dec.link_wr  = 1'b1;
                        dec.link_val = {link_in[ADDR_W-1:1], 1'b0};
                    end
                end
                EV_TOKEN: begin
                    if (!cur_sec) begin
                        if (stk_empty) begin
                            dec.fault = 1'b1;
                        end else begin
                            dec.next_sec  = 1'b1;
                            dec.pop       = 1'b1;
                            dec.redir     = 1'b1;
                            dec.redir_val = stack_top;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sstc_depth_track.sv
// Module: sstc_depth_track
// Counts entries on the Secure stack so that the rules can see empty/full.
// Assumes the caller never pushes when full nor pops when empty; such
// requests are ignored. A depth of zero gives a stack that is always empty
// and always full.
module sstc_depth_track #(
    parameter int STACK_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic empty,
    output logic full
);

    generate
        if (STACK_DEPTH == 0) begin : g_none
            assign empty = 1'b1;
            assign full  = 1'b1;
        end else begin : g_cnt
            localparam int CW = $clog2(STACK_DEPTH + 1);
            logic [CW-1:0] cnt;

            // Track occupancy, one change per cycle at most.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (push && !full) begin
                    cnt <= cnt + 1'b1;
                end else if (pop && !empty) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign empty = (cnt == '0);
            assign full  = (cnt == CW'(STACK_DEPTH));
        end
    endgenerate

endmodule

// File: rtl/sstc_out_reg.sv
// Module: sstc_out_reg
// Registers the decision record: the security state and every strobe and
// data output. Strobes are cleared each cycle unless the new decision sets
// them, which makes each one a single-cycle pulse.
module sstc_out_reg
    import sstc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  decision_t         dec,
    output logic              sec,
    output logic              link_wr,
    output logic [ADDR_W-1:0] link_val,
    output logic              push,
    output logic [ADDR_W-1:0] push_val,
    output logic              pop,
    output logic              redir,
    output logic [ADDR_W-1:0] redir_val,
    output logic              fault
);

    // Capture the decision; reset lands in Secure with all strobes low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec       <= 1'b1;
            link_wr   <= 1'b0;
            link_val  <= '0;
            push      <= 1'b0;
            push_val  <= '0;
            pop       <= 1'b0;
            redir     <= 1'b0;
            redir_val <= '0;
            fault     <= 1'b0;
        end else begin
            sec       <= dec.next_sec;
            link_wr   <= dec.link_wr;
            link_val  <= dec.link_val;
            push      <= dec.push;
            push_val  <= dec.push_val;
            pop       <= dec.pop;
            redir     <= dec.redir;
            redir_val <= dec.redir_val;
            fault     <= dec.fault;
        end
    end

endmodule

// File: rtl/sec_state_ctrl.sv
// Module: sec_state_ctrl
// Top of the security state transition controller. It ties the rule
// evaluator to the registered outputs and to the stack occupancy counter.
// Assumes the Secure stack outside presents its top entry on stack_top_i
// whenever it is non-empty and acts on push/pop requests in the cycle they
// are raised.
module sec_state_ctrl #(
    parameter int STACK_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  ev_i,
    input  logic [31:0] target_i,
    input  logic [31:0] ret_addr_i,
    input  logic [31:0] link_in_i,
    input  logic        fetch_vld_i,
    input  logic [1:0]  fetch_attr_i,
    input  logic [31:0] stack_top_i,
    output logic        sec_state_o,
    output logic        link_wr_o,
    output logic [31:0] link_o,
    output logic        push_req_o,
    output logic [31:0] push_data_o,
    output logic        pop_req_o,
    output logic        redirect_vld_o,
    output logic [31:0] redirect_addr_o,
    output logic        fault_o
);
    import sstc_pkg::*;

    decision_t dec;
    logic      stack_empty;
    logic      stack_full;

    sstc_rule_eval u_rules (
        .cur_sec    (sec_state_o),
        .ev         (ev_i),
        .target     (target_i),
        .ret_addr   (ret_addr_i),
        .link_in    (link_in_i),
        .fetch_vld  (fetch_vld_i),
        .fetch_attr (fetch_attr_i),
        .stack_top  (stack_top_i),
        .stk_empty  (stack_empty),
        .stk_full   (stack_full),
        .dec        (dec)
    );

    sstc_depth_track #(.STACK_DEPTH(STACK_DEPTH)) u_depth (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dec.push),
        .pop   (dec.pop),
        .empty (stack_empty),
        .full  (stack_full)
    );

    sstc_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .sec       (sec_state_o),
        .link_wr   (link_wr_o),
        .link_val  (link_o),
        .push      (push_req_o),
        .push_val  (push_data_o),
        .pop       (pop_req_o),
        .redir     (redirect_vld_o),
        .redir_val (redirect_addr_o),
        .fault     (fault_o)
    );

endmodule

// File: rtl/sstc_checker.sv
// Module: sstc_checker
// Temporal properties of the controller, bound to the top module. Observes
// ports plus the stack occupancy flags of the counter.
module sstc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  ev_i,
    input logic [31:0] target_i,
    input logic [31:0] ret_addr_i,
    input logic        fetch_vld_i,
    input logic [1:0]  fetch_attr_i,
    input logic        sec_state_o,
    input logic        link_wr_o,
    input logic [31:0] link_o,
    input logic        push_req_o,
    input logic [31:0] push_data_o,
    input logic        pop_req_o,
    input logic        fault_o,
    input logic        stack_empty,
    input logic        stack_full
);

    // R2: leaving Secure on a cleared target LSB
    p_leave_secure_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_state_o && ev_i == 3'd1 && !target_i[0]) |=> !sec_state_o);

    // R3: branch-with-link writes the token and pushes the return address
    p_token_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_state_o && ev_i == 3'd2 && !target_i[0] && !stack_full)
        |=> (link_wr_o && link_o == 32'hFEFF_FFFF && push_req_o
             && push_data_o == $past(ret_addr_i)));

    // R4: Secure entry only through a gateway or a token branch
    p_entry_paths_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_state_o) |-> ($past(ev_i) == 3'd3 || $past(ev_i) == 3'd4));

    // R4: gateway entry clears the link LSB
    p_gate_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sec_state_o) && $past(ev_i) == 3'd3) |-> (link_wr_o && !link_o[0]));

    // R7: token branch with an empty stack faults and stays Non-secure
    p_empty_token_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_state_o && ev_i == 3'd4 && stack_empty)
        |=> (fault_o && !sec_state_o && !pop_req_o));

    // R8: a Secure fetch from Non-secure state faults
    p_fetch_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_state_o && fetch_vld_i && fetch_attr_i[1]) |=> (fault_o && !sec_state_o));

    // R8: a fault never comes with a state change
    p_fault_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $stable(sec_state_o));

    // R11: push and pop are never requested together
    p_no_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req_o && pop_req_o));

endmodule

bind sec_state_ctrl sstc_checker u_sstc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_i         (ev_i),
    .target_i     (target_i),
    .ret_addr_i   (ret_addr_i),
    .fetch_vld_i  (fetch_vld_i),
    .fetch_attr_i (fetch_attr_i),
    .sec_state_o  (sec_state_o),
    .link_wr_o    (link_wr_o),
    .link_o       (link_o),
    .push_req_o   (push_req_o),
    .push_data_o  (push_data_o),
    .pop_req_o    (pop_req_o),
    .fault_o      (fault_o),
    .stack_empty  (stack_empty),
    .stack_full   (stack_full)
);

// File: tb/tb_sec_state_ctrl.sv
// Directed bench for sec_state_ctrl: one task per scenario, each checking
// its own results half a cycle after the edge that registers them.
module tb_sec_state_ctrl;

    logic        clk;
    logic        rst_n;
    logic [2:0]  ev_i;
    logic [31:0] target_i;
    logic [31:0] ret_addr_i;
    logic [31:0] link_in_i;
    logic        fetch_vld_i;
    logic [1:0]  fetch_attr_i;
    logic [31:0] stack_top_i;
    logic        sec_state_o;
    logic        link_wr_o;
    logic [31:0] link_o;
    logic        push_req_o;
    logic [31:0] push_data_o;
    logic        pop_req_o;
    logic        redirect_vld_o;
    logic [31:0] redirect_addr_o;
    logic        fault_o;

    int n_chk;
    int n_bad;

    sec_state_ctrl #(.STACK_DEPTH(4)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ev_i            (ev_i),
        .target_i        (target_i),
        .ret_addr_i      (ret_addr_i),
        .link_in_i       (link_in_i),
        .fetch_vld_i     (fetch_vld_i),
        .fetch_attr_i    (fetch_attr_i),
        .stack_top_i     (stack_top_i),
        .sec_state_o     (sec_state_o),
        .link_wr_o       (link_wr_o),
        .link_o          (link_o),
        .push_req_o      (push_req_o),
        .push_data_o     (push_data_o),
        .pop_req_o       (pop_req_o),
        .redirect_vld_o  (redirect_vld_o),
        .redirect_addr_o (redirect_addr_o),
        .fault_o         (fault_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one event at a falling edge, let one rising edge take it, and
    // return at the next falling edge with the inputs idle again.
    task automatic apply(input logic [2:0] ev, input logic [31:0] tgt,
                         input logic [31:0] ret, input logic [31:0] lnk,
                         input logic fv, input logic [1:0] at);
        ev_i         = ev;
        target_i     = tgt;
        ret_addr_i   = ret;
        link_in_i    = lnk;
        fetch_vld_i  = fv;
        fetch_attr_i = at;
        @(negedge clk);
        ev_i        = 3'd0;
        fetch_vld_i = 1'b0;
    endtask

    task automatic to_ns();
        apply(3'd1, 32'h0000_0100, 32'h0, 32'h0, 1'b0, 2'd0);
    endtask

    task automatic to_s();
        apply(3'd3, 32'h0, 32'h0, 32'h0000_0011, 1'b1, 2'd1);
    endtask

    task automatic t_reset();
        chk("R1 state", {31'd0, sec_state_o}, 32'd1);
        chk("R1 strobes", {27'd0, link_wr_o, push_req_o, pop_req_o, redirect_vld_o, fault_o}, 32'd0);
    endtask

    task automatic t_leave();
        apply(3'd1, 32'h0000_1000, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R2 state", {31'd0, sec_state_o}, 32'd0);
        chk("R2 redirect", redirect_vld_o ? redirect_addr_o : 32'hDEAD_DEAD, 32'h0000_1000);
        // back to Secure through a gateway
        apply(3'd3, 32'h0, 32'h0, 32'h0000_2001, 1'b1, 2'd1);
        chk("R4 state", {31'd0, sec_state_o}, 32'd1);
        chk("R4 link", link_wr_o ? link_o : 32'hDEAD_DEAD, 32'h0000_2000);
        // LSB set keeps Secure
        apply(3'd1, 32'h0000_3001, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R2 lsb1 state", {31'd0, sec_state_o}, 32'd1);
        chk("R2 lsb1 redirect", redirect_addr_o, 32'h0000_3000);
        chk("R11 pulse", {31'd0, redirect_vld_o}, 32'd1);
        @(negedge clk);
        chk("R11 pulse end", {31'd0, redirect_vld_o}, 32'd0);
    endtask

    task automatic t_ignored();
        to_ns();
        apply(3'd1, 32'h0000_5000, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R10 ns branch in NS", {30'd0, sec_state_o, redirect_vld_o}, 32'd0);
        to_s();
        apply(3'd4, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R10 token in S", {29'd0, sec_state_o, pop_req_o, fault_o}, 32'd4);
    endtask

    task automatic t_call_return();
        apply(3'd2, 32'h0000_4000, 32'h1000_0101, 32'h0, 1'b0, 2'd0);
        chk("R3 state", {31'd0, sec_state_o}, 32'd0);
        chk("R3 link", link_wr_o ? link_o : 32'hDEAD_DEAD, 32'hFEFF_FFFF);
        chk("R3 push", push_req_o ? push_data_o : 32'hDEAD_DEAD, 32'h1000_0101);
        stack_top_i = 32'h1000_0101;
        apply(3'd4, 32'hFEFF_FFFF, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R6 state", {31'd0, sec_state_o}, 32'd1);
        chk("R6 pop", {31'd0, pop_req_o}, 32'd1);
        chk("R6 redirect", redirect_vld_o ? redirect_addr_o : 32'hDEAD_DEAD, 32'h1000_0101);
    endtask

    task automatic t_empty_token();
        to_ns();
        apply(3'd4, 32'hFEFF_FFFF, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R7 fault", {31'd0, fault_o}, 32'd1);
        chk("R7 state/pop", {30'd0, sec_state_o, pop_req_o}, 32'd0);
        @(negedge clk);
        chk("R7 fault pulse", {31'd0, fault_o}, 32'd0);
    endtask

    task automatic t_gate_denied();
        apply(3'd3, 32'h0, 32'h0, 32'h0000_7001, 1'b1, 2'd0);
        chk("R5 ns attr", {30'd0, sec_state_o, link_wr_o}, 32'd0);
        to_s();
        apply(3'd3, 32'h0, 32'h0, 32'h0000_7001, 1'b1, 2'd1);
        chk("R5 secure state", {30'd0, sec_state_o, link_wr_o}, 32'd2);
    endtask

    task automatic t_fetch_fault();
        to_ns();
        apply(3'd3, 32'h0, 32'h0, 32'h0000_8001, 1'b1, 2'd2);
        chk("R8 fault", {31'd0, fault_o}, 32'd1);
        chk("R8 suppressed", {30'd0, sec_state_o, link_wr_o}, 32'd0);
        @(negedge clk);
        chk("R8 fault pulse", {31'd0, fault_o}, 32'd0);
        to_s();
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) begin
            apply(3'd2, 32'h0000_9000, 32'h2000_0000 + i, 32'h0, 1'b0, 2'd0);
            to_s();
        end
        apply(3'd2, 32'h0000_9000, 32'h2000_0010, 32'h0, 1'b0, 2'd0);
        chk("R9 fault", {31'd0, fault_o}, 32'd1);
        chk("R9 state/push", {30'd0, sec_state_o, push_req_o}, 32'd2);
    endtask

    initial begin
        n_chk = 0;
        n_bad = 0;
        rst_n = 1'b0;
        ev_i = 3'd0; target_i = '0; ret_addr_i = '0; link_in_i = '0;
        fetch_vld_i = 1'b0; fetch_attr_i = 2'd0; stack_top_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_leave();
        t_ignored();
        t_call_return();
        t_empty_token();
        t_gate_denied();
        t_fetch_fault();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule